// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several devices on a shared bus may drive it next. It has one central arbiter and a chain of per-device cells, with one cell for each device. Every request line feeds a single wired-OR request, which the arbiter sees. When the bus is free and that combined request is high, the arbiter sends one grant pulse into the chain at device 0. A requesting cell keeps the pulse. A cell that is not requesting passes it on to the next cell. Position in the chain is therefore the only priority: device 0 is the highest and device N-1 the lowest.

The cell that captures the grant becomes the owner. It keeps ownership until it raises its release line. Requests that arrive while the bus is held have no effect, including a request from a device of higher priority than the owner. After a release the bus is free for one cycle before the next grant is issued. The arbiter does nothing to share the bus fairly, so a device near the head of the chain that requests all the time locks out every device behind it.

Top module: `daisy_arb_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, grant_o is all zeros and busy_o is 0.
- R2: If busy_o is 0 and at least one request is high at a rising edge, then after that edge grant_o has exactly the bit of the lowest-numbered requesting device set, and busy_o is 1. Bit i of req_i and grant_o belongs to device i, and device 0 has the highest priority.
- R3: grant_o never has more than one bit set.
- R4: While the bus is held and the owner does not release, grant_o stays unchanged. This holds whatever req_i does, including when a higher-priority device starts requesting or the owner drops its own request.
- R5: If the owner has its release_i bit high at a rising edge, then after that edge grant_o is all zeros and busy_o is 0.
- R6: release_i bits of devices that do not own the bus are ignored, whether the bus is held or idle.
- R7: After a release the bus stays free for one full cycle. A new grant appears only at the edge after that cycle, even if requests were held high all the way through the release.
- R8: If busy_o is 0 and no request is high, the bus stays free and grant_o stays all zeros.
- R9: There is no fairness. If device 0 requests without pause, it wins every arbitration, and a lower-priority device that requests at the same time never receives the grant.
- R10: busy_o is 1 exactly when grant_o has a bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Per-device bus request, bit 0 has the highest priority |
| release_i | input | N_DEV | Per-device release; only the owner's bit has an effect |
| grant_o | output | N_DEV | One-hot grant, registered ownership flags of the cells |
| busy_o | output | 1 | The bus is currently owned |

## Verification
Two events can fall in the same cycle: the owner's release, and a request from another device, sometimes one of higher priority than the owner. The random stream produces many of these collisions, and directed sequences force them while every request is held high. The bench judges the result against a model written in the bench itself. That model expects a free cycle right after the release and, one edge later, a grant to the lowest requesting index. It also checks that nothing changes when a request arrives in the middle of an ownership.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;

  typedef enum logic [0:0] {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

endpackage

// File: rtl/daisy_arb_ctrl.sv
module daisy_arb_ctrl
  import daisy_arb_pkg::*;
#(
  parameter int unsigned N_DEV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic             owner_rel_i,
  input  logic             ack_tail_i,
  output logic             ack_o,
  output logic             busy_o
);

  arb_state_e state_q, state_d;
  logic       wired_req;

  // wired-OR of all request lines
  assign wired_req = |req_i;

  // single grant pulse into the chain head, only while the bus is free
  assign ack_o = (state_q == ARB_FREE) && wired_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_FREE: if (ack_o && !ack_tail_i) state_d = ARB_HELD;
      ARB_HELD: if (owner_rel_i)          state_d = ARB_FREE;
      default:                            state_d = ARB_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_FREE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == ARB_HELD);

endmodule

// File: rtl/daisy_arb_cell.sv
module daisy_arb_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_in_i,
  input  logic req_i,
  input  logic release_i,
  output logic ack_out_o,
  output logic own_o
);

  logic own_q;
  logic take;

  assign take      = ack_in_i & req_i;
  assign ack_out_o = ack_in_i & ~req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 own_q <= 1'b0;
    else if (take)               own_q <= 1'b1;
    else if (own_q && release_i) own_q <= 1'b0;
  end

  assign own_o = own_q;

endmodule

// File: rtl/daisy_arb_top.sv
module daisy_arb_top #(
  parameter int unsigned N_DEV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic [N_DEV-1:0] release_i,
  output logic [N_DEV-1:0] grant_o,
  output logic             busy_o
);

  localparam int unsigned CHAIN_LEN = N_DEV + 1;

  logic [CHAIN_LEN-1:0] ack_chain;
  logic [N_DEV-1:0]     own;
  logic                 owner_rel;

  assign owner_rel = |(own & release_i);

  daisy_arb_ctrl #(.N_DEV(N_DEV)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .owner_rel_i(owner_rel),
    .ack_tail_i (ack_chain[N_DEV]),
    .ack_o      (ack_chain[0]),
    .busy_o     (busy_o)
  );

  for (genvar i = 0; i < N_DEV; i++) begin : g_cell
    daisy_arb_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ack_in_i (ack_chain[i]),
      .req_i    (req_i[i]),
      .release_i(release_i[i]),
      .ack_out_o(ack_chain[i+1]),
      .own_o    (own[i])
    );
  end

  assign grant_o = own;

endmodule

// File: rtl/daisy_arb_chk.sv
module daisy_arb_chk #(
  parameter int unsigned N_DEV = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DEV-1:0] req_i,
  input logic [N_DEV-1:0] release_i,
  input logic [N_DEV-1:0] grant_o,
  input logic             busy_o
);

  logic [N_DEV-1:0] lowest_req;
  logic             owner_rel;

  assign lowest_req = req_i & (~req_i + N_DEV'(1));
  assign owner_rel  = |(grant_o & release_i);

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R3

  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (grant_o != '0)); // R10

  AST_GRANT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (req_i != '0)) |=> (grant_o == $past(lowest_req))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !owner_rel) |=> $stable(grant_o)); // R4

  AST_RELEASE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_rel |=> (grant_o == '0 && !busy_o)); // R5

  AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i == '0) |=> (grant_o == '0)); // R8

endmodule

bind daisy_arb_top daisy_arb_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .release_i(release_i),
  .grant_o  (grant_o),
  .busy_o   (busy_o)
);

// File: tb/tb_daisy_arb_top.sv
`timescale 1ns/1ps
module tb_daisy_arb_top;

  localparam int unsigned N = 8;
  localparam int unsigned WDOG = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] grant;
  logic         busy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [N-1:0] model_g = '0;

  always #2.5 clk = ~clk;

  daisy_arb_top #(.N_DEV(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .release_i(rel),
    .grant_o(grant), .busy_o(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [N-1:0] next_grant(logic [N-1:0] cur, logic [N-1:0] r,
                                               logic [N-1:0] rl);
    if (cur != '0) return ((cur & rl) != '0) ? '0 : cur;
    return r & (~r + N'(1));
  endfunction

  task automatic chk(string tag, logic [N:0] act, logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, compare grant/busy after the edge
  task automatic step(logic [N-1:0] r, logic [N-1:0] rl, string tag);
    logic [N-1:0] e;
    @(negedge clk);
    req = r;
    rel = rl;
    e = next_grant(model_g, r, rl);
    @(posedge clk);
    #1;
    chk(tag, {busy, grant}, {(e != '0), e});
    model_g = e;
  endtask

  function automatic string pick_tag(logic [N-1:0] r, logic [N-1:0] rl);
    if (model_g != '0 && (model_g & rl) != '0) return "R5";
    if (model_g != '0 && rl != '0) return "R6";
    if (model_g != '0) return "R4";
    if (r != '0) return "R2";
    if (rl != '0) return "R6";
    return "R8";
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R1 in reset", {busy, grant}, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 after reset", {busy, grant}, '0);

    // R8: idle stays idle
    step('0, '0, "R8 idle");
    // R6: stray release while free
    step('0, 8'hFF, "R6 release while free");
    // R2: lowest index wins
    step(8'b1010_0100, '0, "R2 priority pick");
    // R4: higher-priority request and owner dropping request
    step(8'b0000_0011, '0, "R4 higher prio arrives");
    step('0, '0, "R4 owner drops req");
    // R6: non-owner release while held
    step(8'hFF, 8'b1111_1011, "R6 non-owner release");
    // R5 + R7: release with all requests held
    step(8'hFF, 8'b0000_0100, "R5 release");
    chk("R7 free cycle after release", {busy, grant}, '0);
    step(8'hFF, '0, "R7 regrant one edge later");
    chk("R10 busy with grant", {busy, grant}, {1'b1, 8'h01});
    step(8'hFF, 8'h01, "R5 release head");

    // R9: starvation of device N-1
    begin
      int tail_wins = 0;
      for (int k = 0; k < 30; k++) begin
        logic [N-1:0] r;
        r = N'($urandom) | 8'h81;
        step(r, '0, "R9 arbitrate");
        if (grant[N-1]) tail_wins++;
        chk("R9 head wins", {1'b0, grant}, {1'b0, 8'h01});
        step(r, 8'h01, "R9 release");
      end
      chk("R9 tail never granted", N'(tail_wins), '0);
    end

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r;
      logic [N-1:0] rl;
      r  = ($urandom % 4 == 0) ? '0 : N'($urandom) & N'($urandom);
      rl = ($urandom % 3 == 0) ? model_g : '0;
      if ($urandom % 5 == 0) rl = rl | (N'($urandom) & ~model_g);
      step(r, rl, pick_tag(r, rl));
      checks++;
      if ($countones(grant) > 1) begin
        fails++;
        $display("FAIL R3 actual=%h expected=onehot0", grant);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule